// File: doc/BRIEF.md
# Ethernet Link Status LED Driver

The block turns PHY status into three LED indications. A speed LED lights when the link runs at 100 Mb/s. A duplex LED lights when the link is in full duplex. A link LED lights solid while a link is present, and it blinks when transmit or receive activity arrives. Each LED output is an open-drain style pull request. A 1 means the pad is pulled low and the LED is lit. A 0 means the pad is released.

The blink on the link LED follows a fixed sequence. It goes dark for a fixed interval, then stays lit for at least the same interval. Only after that is activity accepted again. Activity that arrives during either interval is remembered and starts the next blink when the lit interval ends. A free-running divider turns the system clock into a millisecond tick. The interval is a parameter counted in those ticks. When the LED enable input is low, all three pads are released.

Top module: `eth_led_drv`

## Requirements
- R1: `spd_pull` is 1 exactly when `led_en`, `link_up` and `spd_100` are all 1 and `aneg_busy` is 0; otherwise it is 0 (released).
- R2: `dup_pull` is 1 exactly when `led_en`, `link_up` and `full_dup` are all 1; otherwise it is 0.
- R3: With `led_en` and `link_up` high and no blink in its dark interval, `lnk_pull` is 1.
- R4: If `tx_act` or `rx_act` is 1 at a rising clock edge while the link LED is idle and the link is up, `lnk_pull` drops to 0 right after that edge. It stays 0 for exactly BLINK_MS*(CLK_HZ/1000) cycles.
- R5: After the dark interval, `lnk_pull` is 1 for exactly BLINK_MS*(CLK_HZ/1000) cycles, whatever the activity inputs do.
- R6: Activity seen during the dark or lit interval is latched. It starts a new dark interval one clock after the lit interval ends. If no activity was seen, the LED stays solid on.
- R7: While `link_up` is 0, `lnk_pull` is 0, and any blink in progress or latched activity is discarded. When the link returns, the LED is solid on.
- R8: While `led_en` is 0, all three pull outputs are 0.
- R9: After reset, no blink is in progress and no activity is latched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| led_en | input | 1 | LED mode enable; 0 releases all pads |
| link_up | input | 1 | PHY reports a valid link |
| spd_100 | input | 1 | PHY operates at 100 Mb/s |
| full_dup | input | 1 | PHY operates in full duplex |
| aneg_busy | input | 1 | Auto-negotiation in progress |
| tx_act | input | 1 | Transmit activity pulse |
| rx_act | input | 1 | Receive activity pulse |
| spd_pull | output | 1 | 1 pulls the speed LED pad low |
| lnk_pull | output | 1 | 1 pulls the link/activity LED pad low |
| dup_pull | output | 1 | 1 pulls the duplex LED pad low |

## Verification
The hardest case to reach is a second blink triggered only by a latched pulse. It also shows whether a lost link throws away latched activity. The stimulus fires one activity pulse and then a second pulse inside the dark interval. It then checks `lnk_pull` at the exact cycles where the lit interval ends and the new dark interval must begin. In a separate run, a pulse is latched and the link is then dropped in the middle of the blink. After the link comes back, the bench checks that the LED stays solidly lit.

// File: rtl/eth_led_pkg.sv
package eth_led_pkg;
  typedef enum logic [1:0] {
    LS_SOLID = 2'd0,
    LS_DARK  = 2'd1,
    LS_LIT   = 2'd2
  } lnk_state_t;
endpackage

// File: rtl/eth_led_mstick.sv
module eth_led_mstick #(
  parameter int unsigned CLK_HZ = 25_000_000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  output logic tick
);
  localparam int unsigned DIV = (CLK_HZ / 1000 > 0) ? CLK_HZ / 1000 : 1;
  localparam int unsigned CW  = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt_q, cnt_d;

  assign tick = (cnt_q == LAST);

  always_comb begin
    cnt_d = cnt_q;
    if (restart || tick) cnt_d = '0;
    else                 cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  generate
    if (DIV > 1) begin : g_chk
      AST_TICK_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick); // R4
    end
  endgenerate
endmodule

// File: rtl/eth_led_blink.sv
module eth_led_blink
  import eth_led_pkg::*;
#(
  parameter int unsigned BLINK_MS = 80
) (
  input  logic clk,
  input  logic rst_n,
  input  logic link_up,
  input  logic act,
  input  logic tick,
  output logic restart,
  output logic dark
);
  localparam int unsigned MSW = (BLINK_MS > 1) ? $clog2(BLINK_MS) : 1;
  localparam logic [MSW-1:0] MS_LAST = MSW'(BLINK_MS - 1);

  lnk_state_t     st_q, st_d;
  logic [MSW-1:0] ms_q, ms_d;
  logic           pend_q, pend_d;

  always_comb begin
    st_d    = st_q;
    ms_d    = ms_q;
    pend_d  = pend_q | act;
    restart = 1'b0;
    if (!link_up) begin
      st_d   = LS_SOLID;
      ms_d   = '0;
      pend_d = 1'b0;
    end else begin
      case (st_q)
        LS_SOLID: begin
          if (act || pend_q) begin
            st_d    = LS_DARK;
            ms_d    = '0;
            pend_d  = 1'b0;
            restart = 1'b1;
          end
        end
        LS_DARK, LS_LIT: begin
          if (tick) begin
            if (ms_q == MS_LAST) begin
              st_d = (st_q == LS_DARK) ? LS_LIT : LS_SOLID;
              ms_d = '0;
            end else begin
              ms_d = ms_q + 1'b1;
            end
          end
        end
        default: begin
          st_d = LS_SOLID;
          ms_d = '0;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= LS_SOLID;
      ms_q   <= '0;
      pend_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      ms_q   <= ms_d;
      pend_q <= pend_d;
    end
  end

  assign dark = (st_q == LS_DARK);

  AST_DARK_FROM_SOLID: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == LS_DARK && $past(st_q) != LS_DARK) |-> $past(st_q) == LS_SOLID); // R4
  AST_LIT_AFTER_DARK: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == LS_LIT && $past(st_q) != LS_LIT) |-> $past(st_q) == LS_DARK); // R5
  AST_LINK_LOSS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !link_up |=> (st_q == LS_SOLID && !pend_q)); // R7
  AST_PHASE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    ms_q <= MS_LAST); // R5
endmodule

// File: rtl/eth_led_drv.sv
module eth_led_drv #(
  parameter int unsigned CLK_HZ   = 25_000_000,
  parameter int unsigned BLINK_MS = 80
) (
  input  logic clk,
  input  logic rst_n,
  input  logic led_en,
  input  logic link_up,
  input  logic spd_100,
  input  logic full_dup,
  input  logic aneg_busy,
  input  logic tx_act,
  input  logic rx_act,
  output logic spd_pull,
  output logic lnk_pull,
  output logic dup_pull
);
  logic [1:0] rsync_q;
  logic       rst_i_n;
  logic       tick, restart, dark;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_i_n = rsync_q[1];

  eth_led_mstick #(.CLK_HZ(CLK_HZ)) i_tick (
    .clk     (clk),
    .rst_n   (rst_i_n),
    .restart (restart),
    .tick    (tick)
  );

  eth_led_blink #(.BLINK_MS(BLINK_MS)) i_blink (
    .clk     (clk),
    .rst_n   (rst_i_n),
    .link_up (link_up),
    .act     (tx_act | rx_act),
    .tick    (tick),
    .restart (restart),
    .dark    (dark)
  );

  assign spd_pull = led_en & link_up & spd_100 & ~aneg_busy;
  assign dup_pull = led_en & link_up & full_dup;
  assign lnk_pull = led_en & link_up & ~dark;

  AST_DARK_NEEDS_LINK: assert property (@(posedge clk) disable iff (!rst_i_n)
    dark |-> $past(link_up)); // R7
endmodule

// File: tb/test_eth_led_drv.sv
`timescale 1ns/1ps
module test_eth_led_drv;
  localparam int unsigned CLK_HZ   = 5000;
  localparam int unsigned BLINK_MS = 80;
  localparam int unsigned T = BLINK_MS * (CLK_HZ / 1000);

  logic clk = 1'b0;
  logic rst_n, led_en, link_up, spd_100, full_dup, aneg_busy, tx_act, rx_act;
  logic spd_pull, lnk_pull, dup_pull;
  int total = 0;
  int bad = 0;
  int m;

  always #5 clk = ~clk;

  eth_led_drv #(.CLK_HZ(CLK_HZ), .BLINK_MS(BLINK_MS)) i_eth_led_drv (
    .clk(clk), .rst_n(rst_n), .led_en(led_en), .link_up(link_up),
    .spd_100(spd_100), .full_dup(full_dup), .aneg_busy(aneg_busy),
    .tx_act(tx_act), .rx_act(rx_act),
    .spd_pull(spd_pull), .lnk_pull(lnk_pull), .dup_pull(dup_pull)
  );

  task automatic chk(input string req, input logic actual, input logic expect_v);
    total++;
    if (actual !== expect_v) begin
      bad++;
      $display("FAIL %s at m=%0d: actual=%b expected=%b", req, m, actual, expect_v);
    end
  endtask

  task automatic step();
    @(negedge clk);
    m++;
    #1;
  endtask

  task automatic run_to(input int target);
    while (m < target) step();
  endtask

  // Pulse one activity input at the current negedge; sampled at next posedge.
  // Returns with m = 0 at the negedge after that posedge.
  task automatic start_blink(input bit use_rx);
    @(negedge clk);
    if (use_rx) rx_act = 1'b1; else tx_act = 1'b1;
    @(negedge clk);
    rx_act = 1'b0; tx_act = 1'b0;
    m = 0;
    #1;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    m = 0;
    rst_n = 1'b0; led_en = 1'b1; link_up = 1'b1; spd_100 = 1'b0;
    full_dup = 1'b0; aneg_busy = 1'b0; tx_act = 1'b0; rx_act = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    #1;
    // R9: reset leaves link LED solid, no blink
    chk("R9 reset solid", lnk_pull, 1'b1);
    repeat (20) @(negedge clk);
    #1;
    chk("R9 no latched blink", lnk_pull, 1'b1);

    // Sweep of static inputs: R1 R2 R3 R8
    for (int c = 0; c < 32; c++) begin
      @(negedge clk);
      {led_en, link_up, spd_100, full_dup, aneg_busy} = 5'(c);
      #1;
      chk("R1 speed", spd_pull, led_en & link_up & spd_100 & ~aneg_busy);
      chk("R2 duplex", dup_pull, led_en & link_up & full_dup);
      chk("R3/R8 link", lnk_pull, led_en & link_up);
      if (!led_en) chk("R8 released", spd_pull | lnk_pull | dup_pull, 1'b0);
    end

    @(negedge clk);
    led_en = 1'b1; link_up = 1'b1; spd_100 = 1'b1; full_dup = 1'b1; aneg_busy = 1'b0;
    repeat (3) @(negedge clk);

    // Scenario A: single blink, no latched activity (R4 R5 R6)
    start_blink(1'b1);
    chk("R4 dark start", lnk_pull, 1'b0);
    run_to(T - 1); chk("R4 dark last", lnk_pull, 1'b0);
    run_to(T);     chk("R5 lit start", lnk_pull, 1'b1);
    run_to(2*T - 1); chk("R5 lit last", lnk_pull, 1'b1);
    run_to(2*T + 3); chk("R6 no activity stays on", lnk_pull, 1'b1);

    // Scenario B: pulse latched in dark phase, serviced after lit phase (R6)
    start_blink(1'b0);
    run_to(10);
    tx_act = 1'b1; step(); tx_act = 1'b0;
    run_to(T - 1); chk("R4 dark despite pulse", lnk_pull, 1'b0);
    run_to(T);     chk("R5 lit", lnk_pull, 1'b1);
    run_to(T + 5);
    rx_act = 1'b1; step(); rx_act = 1'b0;
    chk("R5 pulse ignored in lit", lnk_pull, 1'b1);
    run_to(2*T);   chk("R6 solid one cycle", lnk_pull, 1'b1);
    run_to(2*T + 1); chk("R6 latched blink", lnk_pull, 1'b0);
    // that new blink runs a full dark phase starting at m=2T+1
    run_to(3*T);   chk("R6 second dark", lnk_pull, 1'b0);
    run_to(3*T + 1); chk("R6 second lit", lnk_pull, 1'b1);
    run_to(4*T + 5); chk("R6 settled", lnk_pull, 1'b1);

    // Scenario C: link loss cancels blink and latched activity (R7)
    start_blink(1'b1);
    run_to(20);
    rx_act = 1'b1; step(); rx_act = 1'b0;
    run_to(50);
    link_up = 1'b0; #1;
    chk("R7 link lost off", lnk_pull, 1'b0);
    chk("R1 speed off no link", spd_pull, 1'b0);
    chk("R2 duplex off no link", dup_pull, 1'b0);
    run_to(52);
    link_up = 1'b1; #1;
    chk("R7 blink cancelled", lnk_pull, 1'b1);
    run_to(2*T + 10);
    chk("R7 latched pulse dropped", lnk_pull, 1'b1);

    // R8: disable during blink releases pads
    start_blink(1'b0);
    led_en = 1'b0; #1;
    chk("R8 link released", lnk_pull, 1'b0);
    chk("R8 speed released", spd_pull, 1'b0);
    chk("R8 duplex released", dup_pull, 1'b0);
    led_en = 1'b1;
    run_to(T - 1); chk("R4 dark continues", lnk_pull, 1'b0);
    run_to(T); chk("R5 lit after", lnk_pull, 1'b1);
    aneg_busy = 1'b1; #1;
    chk("R1 speed off during aneg", spd_pull, 1'b0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule